// File: doc/BRIEF.md
# Event Status and Interrupt Mask Unit

This block collects six single-cycle event pulses from a data-processing engine into a sticky status register. A status-enable register decides which event sources are recorded at all. A second, independent signal-enable register decides which recorded bits drive a single level-sensitive interrupt line. Because the two masks are separate, software can record an event and poll for it without the interrupt line ever asserting.

Software reaches the three registers through a plain synchronous register port: one address, a write strobe with write data, and combinational read data. It clears status bits by writing ones to them. A handler can therefore read the status word and write the same value back to acknowledge exactly the events it saw. Events that arrive while that write is in flight are not lost.

Top module: `irq_status_unit`

## Requirements
- R1: After reset the status, status-enable and signal-enable registers all read 0 and the interrupt output is 0.
- R2: An event pulse on input bit i sets status bit i in the next cycle only when status-enable bit i is 1; with the enable bit 0 the pulse leaves the status bit at 0. Bit positions are 0 transfer complete, 1 main-area DMA, 2 spare-area DMA, 3 ECC error, 4 spare-side event and 5 main-side event.
- R3: A set status bit stays set through idle cycles and through a later write of 0 to its status-enable bit, until software clears it.
- R4: A write to the status register at offset 0x04 clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing back the value just read therefore clears every bit that was read as set.
- R5: When an enabled event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R6: The interrupt output equals the OR over all bits of (status AND signal-enable), registered once, so it follows the status register by one clock cycle.
- R7: After a write of 0 to signal-enable, the interrupt output is 0 from the following cycle, and the status bits still read back unchanged for polling.
- R8: Read data bits 31 down to 6 are always 0, and write data in those bits is discarded.
- R9: Status-enable is at offset 0x08 and signal-enable at offset 0x0C, both read/write. Any other offset reads 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Byte offset of the register accessed |
| reg_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed register, combinational |
| evt_pulse | input | 6 | One-cycle event pulses, one bit per source |
| irq | output | 1 | Level interrupt request |

## Verification
A stuck or wrongly gated status flop shows up on the read port in the cycle right after the pulse or clear that should have changed it. The assertions compare each status bit against the previous cycle's pulse, enable and clear terms. A mistake in the interrupt combine or its mask shows on the irq pin exactly one cycle after the status or signal-enable change. The bench checks both sides of that cycle, so an unregistered output or one that is two cycles late is caught. Priority between a set and a clear is only visible when the two collide, so a dedicated case first makes the bit set and then lands a pulse and a clear on it together.

// File: rtl/irqsu_pkg.sv
package irqsu_pkg;

  // Register window offsets; software depends on these values
  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_ST_EN  = 8'h08;
  localparam logic [7:0] OFS_SIG_EN = 8'h0C;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ST_EN  = 2'd2,
    SEL_SIG_EN = 2'd3
  } reg_sel_e;

  // Next value of one sticky status flop: a set outranks a clear
  function automatic logic sticky_next(input logic cur, input logic set,
                                       input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/irqsu_decode.sv
module irqsu_decode #(
  parameter int unsigned ADDR_W = 8
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  output irqsu_pkg::reg_sel_e  sel,
  output logic                 wr_status,
  output logic                 wr_st_en,
  output logic                 wr_sig_en
);
  import irqsu_pkg::*;

  always_comb begin
    sel = SEL_NONE;
    if (addr == ADDR_W'(OFS_STATUS))      sel = SEL_STATUS;
    else if (addr == ADDR_W'(OFS_ST_EN))  sel = SEL_ST_EN;
    else if (addr == ADDR_W'(OFS_SIG_EN)) sel = SEL_SIG_EN;
  end

  assign wr_status = wr && (sel == SEL_STATUS);
  assign wr_st_en  = wr && (sel == SEL_ST_EN);
  assign wr_sig_en = wr && (sel == SEL_SIG_EN);

endmodule

// File: rtl/irqsu_mask_reg.sv
module irqsu_mask_reg #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

endmodule

// File: rtl/irqsu_status.sv
module irqsu_status #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] st_en,
  input  logic         clr_we,
  input  logic [W-1:0] clr_data,
  output logic [W-1:0] set_hit,
  output logic [W-1:0] clr_hit,
  output logic [W-1:0] status
);
  import irqsu_pkg::*;

  assign set_hit = evt & st_en;
  assign clr_hit = clr_we ? clr_data : '0;

  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status[b] <= 1'b0;
      else        status[b] <= sticky_next(status[b], set_hit[b], clr_hit[b]);
    end
  end

endmodule

// File: rtl/irqsu_irq_out.sv
module irqsu_irq_out #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] sig_en,
  output logic         irq_next,
  output logic         irq
);

  assign irq_next = |(status & sig_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_next;
  end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
  parameter int unsigned EVT_N  = 6,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [EVT_N-1:0]  evt_pulse,
  output logic              irq
);
  import irqsu_pkg::*;

  localparam int unsigned PAD_W = DATA_W - EVT_N;

  reg_sel_e         sel;
  logic             wr_status, wr_st_en, wr_sig_en;
  logic [EVT_N-1:0] wr_bits;
  logic [EVT_N-1:0] st_en_q, sig_en_q, status_q;
  logic [EVT_N-1:0] set_hit, clr_hit;
  logic             irq_next;
  logic [EVT_N-1:0] rd_bits;

  assign wr_bits = reg_wdata[EVT_N-1:0];

  irqsu_decode #(.ADDR_W(ADDR_W)) i_decode (
    .addr      (reg_addr),
    .wr        (reg_wr),
    .sel       (sel),
    .wr_status (wr_status),
    .wr_st_en  (wr_st_en),
    .wr_sig_en (wr_sig_en)
  );

  irqsu_mask_reg #(.W(EVT_N)) i_st_en (
    .clk (clk), .rst_n (rst_n), .we (wr_st_en), .d (wr_bits), .q (st_en_q)
  );

  irqsu_mask_reg #(.W(EVT_N)) i_sig_en (
    .clk (clk), .rst_n (rst_n), .we (wr_sig_en), .d (wr_bits), .q (sig_en_q)
  );

  irqsu_status #(.W(EVT_N)) i_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (evt_pulse),
    .st_en    (st_en_q),
    .clr_we   (wr_status),
    .clr_data (wr_bits),
    .set_hit  (set_hit),
    .clr_hit  (clr_hit),
    .status   (status_q)
  );

  irqsu_irq_out #(.W(EVT_N)) i_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .status   (status_q),
    .sig_en   (sig_en_q),
    .irq_next (irq_next),
    .irq      (irq)
  );

  always_comb begin
    unique case (sel)
      SEL_STATUS: rd_bits = status_q;
      SEL_ST_EN:  rd_bits = st_en_q;
      SEL_SIG_EN: rd_bits = sig_en_q;
      default:    rd_bits = '0;
    endcase
  end

  assign reg_rdata = {{PAD_W{1'b0}}, rd_bits};

endmodule

// File: rtl/irqsu_checker.sv
module irqsu_checker #(
  parameter int unsigned EVT_N  = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EVT_N-1:0]  status,
  input logic [EVT_N-1:0]  sig_en,
  input logic [EVT_N-1:0]  set_hit,
  input logic [EVT_N-1:0]  clr_hit,
  input logic              irq,
  input logic [DATA_W-1:0] rdata
);

  // R2, R5: an enabled pulse always lands in the status register
  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(set_hit)) == $past(set_hit)));

  // R2: a bit only rises when an enabled pulse arrived
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & ~$past(status) & ~$past(set_hit)) == '0));

  // R3: a set bit only falls through a clear
  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(status) & ~$past(clr_hit)) == '0));

  // R4: a clear without a colliding set empties the bit
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_hit & ~set_hit)) == '0));

  // R6, R7: the line follows the masked status one cycle later
  p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & sig_en))));

  // R8: upper read bits are always zero
  p_upper_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:EVT_N] == '0);

endmodule

bind irq_status_unit irqsu_checker #(.EVT_N(EVT_N), .DATA_W(DATA_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .status  (status_q),
  .sig_en  (sig_en_q),
  .set_hit (set_hit),
  .clr_hit (clr_hit),
  .irq     (irq),
  .rdata   (reg_rdata)
);

// File: tb/test_irq_status_unit.sv
module test_irq_status_unit;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_ST = 8'h04, A_SE = 8'h08, A_SG = 8'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [5:0]  evt_pulse = '0;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk (clk), .rst_n (rst_n), .reg_addr (reg_addr), .reg_wr (reg_wr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .evt_pulse (evt_pulse),
    .irq (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [5:0] m);
    @(negedge clk);
    evt_pulse = m;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_ST, d); chk("R1 status", d, 0);
    rd(A_SE, d); chk("R1 st_en", d, 0);
    rd(A_SG, d); chk("R1 sig_en", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_gating();
    logic [31:0] d;
    pulse(6'h3F);
    rd(A_ST, d); chk("R2 disabled", d, 0);
    wr(A_SE, 32'h15);
    pulse(6'h3F);
    rd(A_ST, d); chk("R2 partial", d, 32'h15);
    wr(A_ST, 32'h3F);
    wr(A_SE, 32'h3F);
    for (int i = 0; i < 6; i++) begin
      pulse(6'(1 << i));
      rd(A_ST, d); chk("R2 per bit", d, 32'(1 << i));
      wr(A_ST, 32'(1 << i));
    end
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(6'h08);
    idle(5);
    rd(A_ST, d); chk("R3 idle", d, 32'h08);
    wr(A_SE, 0);
    idle(2);
    rd(A_ST, d); chk("R3 st_en off", d, 32'h08);
    wr(A_SE, 32'h3F);
    wr(A_ST, 32'h08);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    pulse(6'h3F);
    wr(A_ST, 0);
    rd(A_ST, d); chk("R4 zero write", d, 32'h3F);
    wr(A_ST, 32'h05);
    rd(A_ST, d); chk("R4 partial", d, 32'h3A);
    rd(A_ST, d);
    wr(A_ST, d);
    rd(A_ST, d); chk("R4 write back", d, 0);
  endtask

  task automatic t_setwins();
    logic [31:0] d;
    pulse(6'h04);
    @(negedge clk);
    evt_pulse = 6'h04; reg_addr = A_ST; reg_wdata = 32'h06; reg_wr = 1'b1;
    @(negedge clk);
    evt_pulse = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(A_ST, d); chk("R5 set wins", d, 32'h04);
    wr(A_ST, 32'h04);
  endtask

  task automatic t_irq();
    logic [31:0] d;
    wr(A_SG, 32'h01);
    pulse(6'h02);
    idle(2);
    chk("R6 unmasked bit", {31'b0, irq}, 0);
    pulse(6'h01);
    chk("R6 one cycle delay", {31'b0, irq}, 0);
    @(negedge clk);
    chk("R6 raised", {31'b0, irq}, 1);
    wr(A_ST, 32'h01);
    @(negedge clk);
    chk("R6 dropped after clear", {31'b0, irq}, 0);
    rd(A_ST, d); chk("R6 other bit kept", d, 32'h02);
    wr(A_ST, 32'h02);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    wr(A_SG, 32'h20);
    pulse(6'h20);
    @(negedge clk);
    chk("R7 irq on", {31'b0, irq}, 1);
    wr(A_SG, 0);
    @(negedge clk);
    chk("R7 irq off", {31'b0, irq}, 0);
    rd(A_ST, d); chk("R7 poll", d, 32'h20);
    wr(A_ST, 32'h20);
  endtask

  task automatic t_map();
    logic [31:0] d;
    wr(A_SE, 32'hFFFF_FFC0);
    rd(A_SE, d); chk("R8 upper discarded", d, 0);
    wr(A_SE, 32'hFFFF_FFFF);
    rd(A_SE, d); chk("R8 upper zero", d, 32'h3F);
    pulse(6'h3F);
    rd(A_ST, d); chk("R8 status upper", d, 32'h3F);
    rd(8'h00, d); chk("R9 unmapped 00", d, 0);
    rd(8'h10, d); chk("R9 unmapped 10", d, 0);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    rd(A_ST, d); chk("R9 status untouched", d, 32'h3F);
    rd(A_SE, d); chk("R9 st_en untouched", d, 32'h3F);
    rd(A_SG, d); chk("R9 sig_en untouched", d, 0);
    chk("R9 irq quiet", {31'b0, irq}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_gating();
    t_sticky();
    t_w1c();
    t_setwins();
    t_irq();
    t_mask();
    t_map();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule